// File: doc/BRIEF.md
# PWM Timer Channel with One-Shot Mode

This block is one general-purpose timer channel that drives a pulse-width-modulated output. Software sets it up through a small register port (control, period, width, status) and starts or stops it through two single-cycle strobes. The count advances either on every system clock or on each rising edge of an external count clock. That external input is passed through a synchroniser and an edge detector inside the block, and it must run slower than half the system clock.

The channel has two modes. In repeat mode it produces a steady waveform: each period lasts PERIOD counts and is active for its first WIDTH counts. In one-shot mode it emits a single active pulse of exactly WIDTH counts and then stops. A stop strobe never cuts a repeat waveform short; the channel finishes the period in progress and then stops. At the end of each period, or at the end of the one-shot pulse, the channel can set a sticky interrupt flag.

The counting phase starts on the first count event after the start strobe. Because of this, the first count is always a whole count, even with an external clock.

Top module: `pwm_pulse_timer`

## Requirements
- R1: After reset, `pwm_o` is 1 (the inactive level, since polarity resets to active-low), `irq_o` is 0, and status reads 0. Status is at address 3: bit 0 is the interrupt flag and bit 1 is running.
- R2: A start strobe is ignored in each of these cases: control bit 0 (PWM enable) is clear, WIDTH (address 2) is 0, or repeat mode is selected and PERIOD (address 1) is not greater than WIDTH. A stop strobe while idle has no effect.
- R3: One-shot mode (control bit 2 = 0) with the system clock (control bit 1 = 0): the output is active for exactly WIDTH cycles, then the channel stops by itself.
- R4: With control bit 1 = 1, the count advances once per rising edge of `ext_clk_i` after a two-flop synchroniser. The active time is exactly WIDTH external clock periods.
- R5: Repeat mode (control bit 2 = 1): each period lasts PERIOD counts, and the output is active during the first WIDTH counts of each period.
- R6: A stop strobe during a repeat waveform takes effect only at the end of the current period. A stop issued during the arming cycle still lets one full period complete.
- R7: Writes to PERIOD or WIDTH while the channel is running take effect at the next period boundary. A period already in progress keeps its values.
- R8: Control bit 4 set makes the active level high; clear makes it low. When idle, the output sits at the inactive level.
- R9: At each period end, or at the end of a one-shot pulse, the interrupt flag sets if control bit 3 is 1. It does not set if that bit is 0. `irq_o` follows the flag.
- R10: The interrupt flag is sticky. Writing 1 to status bit 0 clears it; writing 0 leaves it unchanged.
- R11: Status bit 1 (running) rises in the cycle after an accepted start strobe. It falls in the cycle after the final period completes, so a one-shot pulse of WIDTH w on the system clock reads running for w+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes (0 control, 1 period, 2 width, 3 status) |
| wdata_i | input | CNT_W | Register write data |
| rdata_o | output | CNT_W | Register read data for `addr_i`, combinational |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop request strobe |
| pwm_o | output | 1 | Modulated output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench counts the active cycles of one-shot pulses clocked from the slow external input and compares them with WIDTH times the external period. A design that starts counting mid-interval would show one count too many or too few. It also issues a stop in the arming cycle of a repeat run. A design that honours the stop at once would cut the period short, and the running time would come out below PERIOD+1.

A width rewritten during the first period, with the stop placed in the second, must yield an active total of the old width plus the new width. A design without shadow copies would apply the new width early. The bench also tries start strobes with zero width, with period equal to width, and with the PWM enable bit clear. It writes zero to the flag as well, where a wrongly decoded clear would drop the flag.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

    // bit 0 pwm_en, bit 1 ext_sel, bit 2 repeat_en, bit 3 irq_en, bit 4 act_high
    typedef struct packed {
        logic act_high;
        logic irq_en;
        logic repeat_en;
        logic ext_sel;
        logic pwm_en;
    } ctrl_t;

    localparam int CTRL_BITS = 5;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_PER  = 2'd1;
    localparam logic [1:0] A_WID  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

endpackage

// File: rtl/pwmt_tick_gen.sv
module pwmt_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel_i,
    input  logic ext_clk_i,
    output logic tick_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } tg_state_t;

    tg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = ext_clk_i;
        for (int i = 1; i < CHAIN_W; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic ext_rise;
    assign ext_rise = s_q.chain[SYNC_STAGES-1] & ~s_q.chain[SYNC_STAGES];

    generate
        if (SYNC_STAGES > 0) begin : g_sel
            assign tick_o = ext_sel_i ? ext_rise : 1'b1;
        end else begin : g_none
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             period_end_i,
    input  logic             running_i,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] rdata_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
        logic             flag;
    } rg_state_t;

    rg_state_t r_d, r_q;
    logic clr_hit;

    always_comb begin
        r_d = r_q;
        clr_hit = wr_en_i && (addr_i == A_STAT) && wdata_i[0];
        if (wr_en_i) begin
            case (addr_i)
                A_CTRL:  r_d.ctrl   = ctrl_t'(wdata_i[CTRL_BITS-1:0]);
                A_PER:   r_d.period = wdata_i;
                A_WID:   r_d.width  = wdata_i;
                default: ;
            endcase
        end
        if (clr_hit) r_d.flag = 1'b0;
        if (period_end_i && r_q.ctrl.irq_en) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:  rdata_o[CTRL_BITS-1:0] = r_q.ctrl;
            A_PER:   rdata_o = r_q.period;
            A_WID:   rdata_o = r_q.width;
            default: begin
                rdata_o[0] = r_q.flag;
                rdata_o[1] = running_i;
            end
        endcase
    end

    assign ctrl_o   = r_q.ctrl;
    assign period_o = r_q.period;
    assign width_o  = r_q.width;
    assign flag_o   = r_q.flag;

    // R10: flag stays set unless a one is written to the clear bit
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !(wr_en_i && addr_i == A_STAT && wdata_i[0])) |=> r_q.flag);

    // R9: flag only rises after a period end with interrupts enabled
    assert_flag_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.flag && !(period_end_i && r_q.ctrl.irq_en)) |=> !r_q.flag);

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  ctrl_t            ctrl_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             running_o,
    output logic             period_end_o,
    output logic             pwm_o
);
    typedef struct packed {
        run_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cur_per;
        logic [CNT_W-1:0] cur_wid;
        logic             cur_rep;
        logic             stop_pend;
    } core_state_t;

    core_state_t c_d, c_q;
    logic start_ok;
    logic reload_ok;
    logic terminal;

    always_comb begin
        c_d = c_q;
        period_end_o = 1'b0;
        start_ok  = (width_i != '0) && (!ctrl_i.repeat_en || (period_i > width_i));
        reload_ok = (width_i != '0) && (period_i > width_i);
        terminal  = c_q.cur_rep ? (c_q.cnt == c_q.cur_per - 1'b1)
                                : (c_q.cnt == c_q.cur_wid - 1'b1);
        case (c_q.state)
            ST_IDLE: begin
                if (start_i && ctrl_i.pwm_en && start_ok) begin
                    c_d.state     = ST_ARMED;
                    c_d.stop_pend = 1'b0;
                    c_d.cur_rep   = ctrl_i.repeat_en;
                    c_d.cur_per   = period_i;
                    c_d.cur_wid   = width_i;
                    c_d.cnt       = '0;
                end
            end
            ST_ARMED: begin
                if (stop_i) c_d.stop_pend = 1'b1;
                if (tick_i) begin
                    c_d.state = ST_RUN;
                    c_d.cnt   = '0;
                end
            end
            ST_RUN: begin
                if (stop_i) c_d.stop_pend = 1'b1;
                if (tick_i) begin
                    if (terminal) begin
                        period_end_o = 1'b1;
                        if (!c_q.cur_rep || c_q.stop_pend || stop_i || !reload_ok) begin
                            c_d.state = ST_IDLE;
                            c_d.cnt   = '0;
                        end else begin
                            c_d.cnt     = '0;
                            c_d.cur_per = period_i;
                            c_d.cur_wid = width_i;
                        end
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic active;
    assign active    = (c_q.state == ST_RUN) && (c_q.cnt < c_q.cur_wid);
    assign pwm_o     = ctrl_i.act_high ? active : ~active;
    assign running_o = (c_q.state != ST_IDLE);

    // R5: in repeat mode the count stays below the captured period
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RUN && c_q.cur_rep) |-> (c_q.cnt < c_q.cur_per));

    // R3: a one-shot run is active in every counting cycle
    assert_oneshot_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RUN && !c_q.cur_rep) |-> (c_q.cnt < c_q.cur_wid));

    // R6: counting only ends on a count event, never straight from a stop
    assert_end_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RUN && !tick_i) |=> (c_q.state == ST_RUN));

    // R7: captured values hold within a period
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RUN && !period_end_o) |=> ($stable(c_q.cur_wid) && $stable(c_q.cur_per)));

    // R2: no start without the PWM enable bit
    assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && !ctrl_i.pwm_en) |=> (c_q.state == ST_IDLE));

endmodule

// File: rtl/pwm_pulse_timer.sv
module pwm_pulse_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             pwm_o,
    output logic             irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] width;
    logic             tick;
    logic             running;
    logic             period_end;
    logic             flag;

    pwmt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sel_i (ctrl.ext_sel),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick)
    );

    pwmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .period_end_i (period_end),
        .running_i    (running),
        .ctrl_o       (ctrl),
        .period_o     (period),
        .width_o      (width),
        .flag_o       (flag),
        .rdata_o      (rdata_o)
    );

    pwmt_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .ctrl_i       (ctrl),
        .period_i     (period),
        .width_i      (width),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .running_o    (running),
        .period_end_o (period_end),
        .pwm_o        (pwm_o)
    );

    assign irq_o = flag;

    // R9: the interrupt output tracks the sticky flag in status
    assert_irq_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_STAT) |-> (rdata_o[0] == irq_o));

endmodule

// File: tb/sim_pwm_pulse_timer.sv
module sim_pwm_pulse_timer;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_clk_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    addr_i = 2'd3;
    logic [CW-1:0] wdata_i = '0;
    logic [CW-1:0] rdata_o;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          pwm_o;
    logic          irq_o;

    int total = 0;
    int bad = 0;
    int ext_n = 4;
    int ext_ph = 0;

    pwm_pulse_timer #(.CNT_W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .start_i(start_i), .stop_i(stop_i), .pwm_o(pwm_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        ext_ph = (ext_ph + 1) % ext_n;
        ext_clk_i = (ext_ph < ext_n / 2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ctrl_word(input bit pwm, input bit ext, input bit rep,
                                     input bit irq, input bit hi);
        return {27'd0, hi, irq, rep, ext, pwm};
    endfunction

    function automatic int exp_active(input int w, input bit ext, input int n);
        return ext ? w * n : w;
    endfunction

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = CW'(d);
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = 2'd3; wdata_i = '0;
    endtask

    // start, then sample each cycle until running drops
    task automatic run(input bit hi, input int stop_at, input int wr_at, input int wr_val,
                       output int act_cnt, output int run_cnt, output bit idle_ok);
        int c;
        act_cnt = 0; run_cnt = 0; c = 0; idle_ok = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            start_i = 1'b0; stop_i = 1'b0; wr_en_i = 1'b0; addr_i = 2'd3;
            #3;
            c++;
            if (!rdata_o[1]) begin
                idle_ok = (pwm_o == !hi);
                break;
            end
            run_cnt++;
            if (pwm_o == hi) act_cnt++;
            if (c > 20000) break;
            @(negedge clk);
            if (c == stop_at) stop_i = 1'b1;
            if (c == wr_at) begin
                wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = CW'(wr_val);
            end
        end
    endtask

    task automatic idle_start(input string req);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(rdata_o[1] == 1'b0, req, int'(rdata_o[1]), 0);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int a, r;
        bit idl;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwm_o == 1'b1, "R1 pwm idle", int'(pwm_o), 1);
        chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
        chk(rdata_o == '0, "R1 status", int'(rdata_o), 0);

        // R2 ignored starts and stop while idle
        wr(2'd1, 10); wr(2'd2, 4);
        wr(2'd0, ctrl_word(0, 0, 0, 1, 0));
        idle_start("R2 pwm enable clear");
        wr(2'd0, ctrl_word(1, 0, 0, 1, 0));
        wr(2'd2, 0);
        idle_start("R2 zero width");
        wr(2'd0, ctrl_word(1, 0, 1, 1, 0));
        wr(2'd1, 5); wr(2'd2, 5);
        idle_start("R2 period not above width");
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        chk(rdata_o[1] == 1'b0 && pwm_o == 1'b1, "R2 stop while idle", int'(pwm_o), 1);
        chk(irq_o == 1'b0, "R9 no flag without period end", int'(irq_o), 0);

        // R3 R11 R9 one-shot on system clock
        wr(2'd0, ctrl_word(1, 0, 0, 1, 1));
        wr(2'd2, 7);
        run(1'b1, -1, -1, 0, a, r, idl);
        chk(a == 7, "R3 one-shot width", a, 7);
        chk(r == 8, "R11 running length", r, 8);
        chk(idl, "R8 idle level high polarity", int'(idl), 1);
        chk(irq_o == 1'b1, "R9 flag set", int'(irq_o), 1);
        // R10 write zero keeps, write one clears
        wr(2'd3, 0);
        chk(irq_o == 1'b1, "R10 write zero keeps flag", int'(irq_o), 1);
        wr(2'd3, 1);
        chk(irq_o == 1'b0, "R10 write one clears flag", int'(irq_o), 0);

        // R4 one-shot on external clock
        ext_n = 6;
        wr(2'd0, ctrl_word(1, 1, 0, 0, 0));
        wr(2'd2, 5);
        run(1'b0, -1, -1, 0, a, r, idl);
        chk(a == exp_active(5, 1, 6), "R4 external width", a, exp_active(5, 1, 6));
        chk(idl, "R8 idle level low polarity", int'(idl), 1);
        chk(irq_o == 1'b0, "R9 flag stays clear when disabled", int'(irq_o), 0);

        // R5 R6 repeat with stop in arming cycle
        wr(2'd0, ctrl_word(1, 0, 1, 0, 1));
        wr(2'd1, 9); wr(2'd2, 3);
        run(1'b1, 1, -1, 0, a, r, idl);
        chk(a == 3, "R5 active per period", a, 3);
        chk(r == 10, "R6 stop waits for period end", r, 10);

        // R7 width rewrite during period one, stop in period two
        wr(2'd1, 8); wr(2'd2, 2);
        run(1'b1, 10, 2, 5, a, r, idl);
        chk(a == 7, "R7 old then new width", a, 7);
        chk(r == 17, "R5 two periods", r, 17);
        chk(rdata_o[1] == 1'b0, "R11 stopped", int'(rdata_o[1]), 0);

        // random mix
        for (int i = 0; i < 24; i++) begin
            bit ext, rep, irq, hi;
            int w, p, n;
            ext = 1'($urandom_range(0, 1));
            rep = 1'($urandom_range(0, 1));
            irq = 1'($urandom_range(0, 1));
            hi  = 1'($urandom_range(0, 1));
            w = $urandom_range(1, 12);
            p = w + $urandom_range(1, 10);
            n = 2 * $urandom_range(2, 4);
            ext_n = n;
            wr(2'd0, ctrl_word(1, ext, rep, irq, hi));
            wr(2'd1, p); wr(2'd2, w);
            run(hi, rep ? 1 : -1, -1, 0, a, r, idl);
            chk(a == exp_active(w, ext, n), ext ? "R4 random active" : "R3 random active",
                a, exp_active(w, ext, n));
            if (!ext)
                chk(r == (rep ? p + 1 : w + 1), "R11 random running", r, rep ? p + 1 : w + 1);
            chk(idl, "R8 random idle level", int'(idl), 1);
            chk(irq_o == irq, "R9 random flag", int'(irq_o), int'(irq));
            wr(2'd3, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule